// File: doc/BRIEF.md
# Bank Open-Row and Precharge Tracker

This block follows the state of a set of memory banks from a stream of decoded commands. Each clock cycle carries one command: none, row activation, write, or precharge. Each command has a bank address and the A10 qualifier bit. For every bank the block reports whether the bank is idle, holds an open row, or is recovering from a precharge. A bank in recovery returns to idle only after the row-precharge recovery time has elapsed.

A write runs for a fixed number of data beats. On each beat the block turns the byte mask inputs into per-byte write enables. When A10 is high on the write, the block precharges the bank itself after the last beat. A precharge with A10 high closes every bank. With A10 low it closes only the addressed bank.

Commands that break the bank protocol raise a one-cycle illegal flag and change no state. A controller or a protocol monitor uses the block to keep its command issue consistent with the state of the banks.

Top module: `bank_tracker`

## Requirements
- R1: While reset is high and on the cycle after it falls, every bank reads idle, `illegal` is low and `wr_en` is all zero. Bank state codes are 0 idle, 1 open and 2 precharging. Bank i occupies `bank_state[2i+1:2i]`.
- R2: The command opcode is 0 none, 1 activate, 2 write and 3 precharge. An activate to an idle bank shows that bank open on the cycle after the command.
- R3: An activate to a bank that is open or precharging raises `illegal` on the next cycle and changes no bank state.
- R4: A legal write starts a burst of BL beats (default 4) on the BL cycles after the command. On the cycle after each beat, `wr_en` equals the bitwise inverse of `dqm` sampled on that beat, so a low mask bit enables its byte. Outside a burst, `wr_en` is zero.
- R5: A write is illegal when its bank is not open, or when a burst is still in progress. It raises `illegal` and starts no burst.
- R6: A write with A10 high leaves the bank open for the burst. The bank shows precharging on the cycle after the last beat.
- R7: A precharge with A10 low moves only the addressed bank from open to precharging. All other banks are unchanged.
- R8: A precharge with A10 high moves every open bank to precharging, whatever the bank address.
- R9: A precharge to a bank that is idle or already precharging is legal, leaves its state as it was, and does not restart its recovery count.
- R10: A bank shows precharging for exactly TRP cycles (default 3) and then idle.
- R11: While one bank is in its automatic precharge, a write to a different open bank is accepted.
- R12: During a burst, a precharge with A10 high, or a precharge with A10 low to the bank being written, is illegal and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 2 | Command opcode: 0 none, 1 activate, 2 write, 3 precharge |
| cmd_bank | input | 2 | Bank address of the command |
| cmd_a10 | input | 1 | Auto precharge on write; all banks on precharge |
| dqm | input | 4 | Byte mask for the current write beat, high masks the byte |
| bank_state | output | 8 | Two-bit state per bank: 0 idle, 1 open, 2 precharging |
| illegal | output | 1 | Pulses one cycle after a rejected command |
| wr_en | output | 4 | Per-byte write enable for the current beat |

## Verification
Assertions check several properties on every cycle. Activations reach only idle banks. Automatic precharge fires only on an open bank. A bank leaves recovery only when its count has run out. A precharge to an idle bank leaves it idle. A new burst never overlaps a running one. An all-bank precharge outside a burst leaves no bank open. Protected precharges during a burst are flagged. Other behaviours need whole command sequences, so only the bench scenarios show them: the exact beat-by-beat mask inversion, the recovery length counted from the precharge, a write accepted during another bank's automatic precharge, and the bank address being ignored on an all-bank precharge.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [1:0] {
    BS_IDLE   = 2'd0,
    BS_OPEN   = 2'd1,
    BS_PRECHG = 2'd2
  } bstate_e;

  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_ACT = 2'd1,
    OP_WR  = 2'd2,
    OP_PRE = 2'd3
  } op_e;
endpackage

// File: rtl/bt_decode.sv
module bt_decode #(
  parameter int NB   = 4,
  parameter int BA_W = 2
) (
  input  logic [1:0]      op,
  input  logic [BA_W-1:0] bank,
  input  logic            a10,
  input  logic [2*NB-1:0] st_vec,
  input  logic            busy,
  input  logic [BA_W-1:0] burst_bank,
  output logic [NB-1:0]   act_hit,
  output logic [NB-1:0]   pre_hit,
  output logic            wr_start,
  output logic            illegal_now
);
  import bt_pkg::*;

  logic [1:0] sel;

  always_comb begin
    sel         = st_vec[2*bank +: 2];
    act_hit     = '0;
    pre_hit     = '0;
    wr_start    = 1'b0;
    illegal_now = 1'b0;
    case (op)
      OP_ACT: begin
        if (sel == BS_IDLE) act_hit[bank] = 1'b1;
        else                illegal_now   = 1'b1;
      end
      OP_WR: begin
        if (sel == BS_OPEN && !busy) wr_start    = 1'b1;
        else                         illegal_now = 1'b1;
      end
      OP_PRE: begin
        if (busy && (a10 || bank == burst_bank)) illegal_now = 1'b1;
        else if (a10)                            pre_hit     = '1;
        else                                     pre_hit[bank] = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bt_bank_fsm.sv
module bt_bank_fsm #(
  parameter int TRP = 3,
  localparam int TW = (TRP > 1) ? $clog2(TRP) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            act,
  input  logic            pre,
  input  logic            ap_fire,
  output bt_pkg::bstate_e state
);
  import bt_pkg::*;

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= BS_IDLE;
      cnt   <= '0;
    end else if (act) begin
      state <= BS_OPEN;
    end else if ((pre || ap_fire) && state == BS_OPEN) begin
      state <= BS_PRECHG;
      cnt   <= TW'(TRP - 1);
    end else if (state == BS_PRECHG) begin
      if (cnt == '0) state <= BS_IDLE;
      else           cnt   <= cnt - 1'b1;
    end
  end

  a_r3_act_only_idle: assert property (@(posedge clk) disable iff (rst)
    act |-> state == BS_IDLE);

  a_r6_ap_on_open: assert property (@(posedge clk) disable iff (rst)
    ap_fire |-> state == BS_OPEN);

  a_r9_pre_idle_stays: assert property (@(posedge clk) disable iff (rst)
    (pre && !act && state == BS_IDLE) |=> state == BS_IDLE);

  a_r10_trp_done: assert property (@(posedge clk) disable iff (rst)
    (state == BS_IDLE && $past(state) == BS_PRECHG && !$past(rst)) |-> $past(cnt) == '0);
endmodule

// File: rtl/bt_burst.sv
module bt_burst #(
  parameter int NB    = 4,
  parameter int BA_W  = 2,
  parameter int BYTES = 4,
  parameter int BL    = 4,
  localparam int CW   = $clog2(BL + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_start,
  input  logic [BA_W-1:0] wr_bank,
  input  logic            wr_a10,
  input  logic [BYTES-1:0] dqm,
  output logic            busy,
  output logic [BA_W-1:0] burst_bank,
  output logic [BYTES-1:0] wr_en,
  output logic [NB-1:0]   ap_fire
);
  logic [CW-1:0] cnt;
  logic          ap_pend;

  assign busy = (cnt != '0);

  generate
    for (genvar i = 0; i < NB; i++) begin : g_ap
      assign ap_fire[i] = ap_pend && (cnt == CW'(1)) && (burst_bank == BA_W'(i));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      ap_pend    <= 1'b0;
      burst_bank <= '0;
      wr_en      <= '0;
    end else begin
      if (busy) begin
        wr_en <= ~dqm;
        cnt   <= cnt - 1'b1;
        if (cnt == CW'(1)) ap_pend <= 1'b0;
      end else begin
        wr_en <= '0;
      end
      if (wr_start) begin
        cnt        <= CW'(BL);
        burst_bank <= wr_bank;
        ap_pend    <= wr_a10;
      end
    end
  end

  a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
    wr_start |-> !busy);

  a_r4_quiet_outside: assert property (@(posedge clk) disable iff (rst)
    !busy |=> wr_en == '0);
endmodule

// File: rtl/bank_tracker.sv
module bank_tracker #(
  parameter int NB    = 4,
  parameter int BYTES = 4,
  parameter int BL    = 4,
  parameter int TRP   = 3,
  localparam int BA_W = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cmd_op,
  input  logic [BA_W-1:0]   cmd_bank,
  input  logic              cmd_a10,
  input  logic [BYTES-1:0]  dqm,
  output logic [2*NB-1:0]   bank_state,
  output logic              illegal,
  output logic [BYTES-1:0]  wr_en
);
  import bt_pkg::*;

  logic [NB-1:0]   act_hit;
  logic [NB-1:0]   pre_hit;
  logic [NB-1:0]   ap_fire;
  logic            wr_start;
  logic            illegal_now;
  logic            busy;
  logic [BA_W-1:0] burst_bank;
  logic            any_open;

  bt_decode #(.NB(NB), .BA_W(BA_W)) u_dec (
    .op(cmd_op), .bank(cmd_bank), .a10(cmd_a10), .st_vec(bank_state),
    .busy(busy), .burst_bank(burst_bank), .act_hit(act_hit),
    .pre_hit(pre_hit), .wr_start(wr_start), .illegal_now(illegal_now)
  );

  bt_burst #(.NB(NB), .BA_W(BA_W), .BYTES(BYTES), .BL(BL)) u_burst (
    .clk(clk), .rst(rst), .wr_start(wr_start), .wr_bank(cmd_bank),
    .wr_a10(cmd_a10), .dqm(dqm), .busy(busy), .burst_bank(burst_bank),
    .wr_en(wr_en), .ap_fire(ap_fire)
  );

  generate
    for (genvar i = 0; i < NB; i++) begin : g_bank
      bstate_e st;
      bt_bank_fsm #(.TRP(TRP)) u_fsm (
        .clk(clk), .rst(rst), .act(act_hit[i]), .pre(pre_hit[i]),
        .ap_fire(ap_fire[i]), .state(st)
      );
      assign bank_state[2*i +: 2] = st;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) illegal <= 1'b0;
    else     illegal <= illegal_now;
  end

  always_comb begin
    any_open = 1'b0;
    for (int i = 0; i < NB; i++)
      if (bank_state[2*i +: 2] == BS_OPEN) any_open = 1'b1;
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (bank_state == '0 && !illegal && wr_en == '0));

  a_r8_all_closed: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == OP_PRE && cmd_a10 && !busy) |=> !any_open);

  a_r12_pre_guard: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == OP_PRE && busy && (cmd_a10 || cmd_bank == burst_bank)) |=> illegal);
endmodule

// File: tb/sim_bank_tracker.sv
module sim_bank_tracker;
  localparam int NB = 4, BYTES = 4, BL = 4, TRP = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cmd_op = 2'd0;
  logic [1:0] cmd_bank = 2'd0;
  logic       cmd_a10 = 1'b0;
  logic [3:0] dqm = 4'hF;
  logic [7:0] bank_state;
  logic       illegal;
  logic [3:0] wr_en;

  bank_tracker #(.NB(NB), .BYTES(BYTES), .BL(BL), .TRP(TRP)) u0 (
    .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .cmd_a10(cmd_a10), .dqm(dqm), .bank_state(bank_state),
    .illegal(illegal), .wr_en(wr_en)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  // behavioural reference model
  int st[4], cnt[4], ost[4];
  int bcnt, bbank;
  bit bap, m_ill, legal, busy;
  logic [3:0] m_we;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin st[i] = 0; cnt[i] = 0; end
      bcnt = 0; bbank = 0; bap = 0; m_ill = 0; m_we = 4'h0;
    end else begin
      ost  = st;
      busy = bcnt > 0;
      case (cmd_op)
        2'd1: legal = (ost[cmd_bank] == 0);
        2'd2: legal = (ost[cmd_bank] == 1) && !busy;
        2'd3: legal = !(busy && (cmd_a10 || cmd_bank == bbank));
        default: legal = 1;
      endcase
      for (int i = 0; i < 4; i++)
        if (st[i] == 2) begin
          if (cnt[i] == 0) st[i] = 0; else cnt[i] = cnt[i] - 1;
        end
      if (busy) begin
        m_we = ~dqm;
        if (bcnt == 1 && bap) begin st[bbank] = 2; cnt[bbank] = TRP - 1; bap = 0; end
        bcnt = bcnt - 1;
      end else m_we = 4'h0;
      if (legal) begin
        case (cmd_op)
          2'd1: st[cmd_bank] = 1;
          2'd2: begin bcnt = BL; bbank = cmd_bank; bap = cmd_a10; end
          2'd3: for (int i = 0; i < 4; i++)
                  if ((cmd_a10 || i == cmd_bank) && ost[i] == 1) begin
                    st[i] = 2; cnt[i] = TRP - 1;
                  end
          default: ;
        endcase
      end
      m_ill = !legal;
    end
  end

  task automatic compare(input string tag);
    logic [7:0] exp_st;
    for (int i = 0; i < 4; i++) exp_st[2*i +: 2] = 2'(st[i]);
    checks += 3;
    if (bank_state !== exp_st) begin
      errors++;
      $display("FAIL %s bank_state actual %h expected %h", tag, bank_state, exp_st);
    end
    if (illegal !== m_ill) begin
      errors++;
      $display("FAIL %s illegal actual %b expected %b", tag, illegal, m_ill);
    end
    if (wr_en !== m_we) begin
      errors++;
      $display("FAIL %s wr_en actual %b expected %b", tag, wr_en, m_we);
    end
  endtask

  task automatic step(input logic [1:0] op, input int b, input bit a, input logic [3:0] dq,
                      input string tag);
    @(negedge clk);
    compare(tag);
    cmd_op = op; cmd_bank = 2'(b); cmd_a10 = a; dqm = dq;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) step(2'd0, 0, 0, 4'hF, "R1");
    rst = 1'b0;
    step(2'd0, 0, 0, 4'hF, "R1");
    step(2'd1, 0, 0, 4'hF, "R2");
    step(2'd1, 0, 0, 4'hF, "R3");   // activate open bank
    step(2'd2, 1, 0, 4'hF, "R5");   // write idle bank
    step(2'd1, 1, 0, 4'hF, "R2");
    step(2'd2, 0, 0, 4'hF, "R4");   // burst on bank 0
    step(2'd0, 0, 0, 4'b0101, "R4");
    step(2'd2, 1, 0, 4'b0000, "R5"); // overlapping write
    step(2'd3, 0, 0, 4'b1100, "R12");
    step(2'd3, 2, 1, 4'b1010, "R12");
    step(2'd0, 0, 0, 4'hF, "R4");
    step(2'd0, 0, 0, 4'hF, "R4");
    step(2'd2, 1, 1, 4'hF, "R6");   // auto precharge write bank 1
    step(2'd0, 0, 0, 4'b0011, "R6");
    step(2'd1, 2, 0, 4'b1110, "R6");
    step(2'd0, 0, 0, 4'b0111, "R6");
    step(2'd0, 0, 0, 4'b1000, "R6");
    step(2'd2, 0, 0, 4'hF, "R11");  // bank 1 auto-precharging
    step(2'd3, 1, 0, 4'b0110, "R9");
    step(2'd1, 1, 0, 4'b1001, "R3");
    step(2'd0, 0, 0, 4'h0, "R10");
    step(2'd1, 1, 0, 4'hF, "R2");
    step(2'd0, 0, 0, 4'hF, "R10");
    step(2'd0, 0, 0, 4'hF, "R10");
    step(2'd3, 0, 0, 4'hF, "R7");
    step(2'd0, 0, 0, 4'hF, "R7");
    step(2'd3, 3, 1, 4'hF, "R8");
    repeat (4) step(2'd0, 0, 0, 4'hF, "R10");
    step(2'd3, 2, 0, 4'hF, "R9");   // idle bank
    for (int b = 0; b < 4; b++) step(2'd1, b, 0, 4'hF, "R2");
    step(2'd3, 0, 1, 4'hF, "R8");
    repeat (5) step(2'd0, 0, 0, 4'hF, "R10");
    @(negedge clk);
    compare("R10");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule